// File: doc/BRIEF.md
# Upper-Memory Shadow Router

This block sits in a host memory controller and decides, for each processor access that falls between 0xC0000 and 0xFFFFF, whether the access is served from on-board DRAM (shadow copy) or passed to the expansion bus where option ROMs and the system ROM live. Reads and writes are routed separately. Firmware therefore can copy a ROM into DRAM in stages: read from ROM while writing to DRAM, then switch reads to DRAM and write-protect the copy.

Three 8-bit control bytes hold the 2-bit routing codes. Each byte is loaded through its own write strobe. The window is split into eight 16 KB segments from 0xC0000 to 0xDFFFF and two 64 KB segments at 0xE0000 and 0xF0000. The routing decision is combinational from the address, the access type and the stored codes. A status flag reports when the system ROM segment is read from DRAM. A bus-level soft reset returns only that segment to ROM, so a warm restart always fetches from the real ROM. The other codes are kept.

Top module: `shadow_router`

## Requirements
- R1: While `rst_n` is low and after it is released, every control byte is zero: every access inside the window routes external (`route_int`=0), and `rom_shadowed` is 0.
- R2: A high `cfg_we[i]` at a rising clock edge loads `cfg_wdata` into control byte i (0, 1 or 2). The new code governs routing from that edge on. A byte whose strobe is low keeps its value.
- R3: Byte 0 holds four 2-bit codes. Bits [1:0] govern 0xC0000–0xC3FFF, [3:2] govern 0xC4000–0xC7FFF, [5:4] govern 0xC8000–0xCBFFF, and [7:6] govern 0xCC000–0xCFFFF. Byte 1 uses the same layout for 0xD0000, 0xD4000, 0xD8000 and 0xDC000.
- R4: In byte 2, bits [5:4] govern the 64 KB segment at 0xF0000 and bits [7:6] govern the 64 KB segment at 0xE0000. Bits [3:0] have no effect on routing.
- R5: Code decode. Bit 1 of a code set sends reads to DRAM, and bit 1 clear sends them external. Bit 0 set sends writes to DRAM, and bit 0 clear sends them external. So code 0 sends both external, code 1 sends only writes to DRAM, code 2 sends only reads to DRAM, and code 3 sends both to DRAM.
- R6: `in_window` is 1 exactly when 0xC0000 ≤ `addr` ≤ 0xFFFFF. Outside the window, `route_int` is 1.
- R7: `rom_shadowed` equals bit 1 of the 0xF0000 code.
- R8: A high `soft_rst` at a rising edge clears byte 2 bits [5:4] and leaves every other bit unchanged. If byte 2 is written at the same edge, the clear wins for bits [5:4] and the write still loads the other bits.
- R9: `route_int` and `in_window` respond to `addr` and `is_write` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous warm reset of the system ROM segment code |
| cfg_we | input | 3 | Per-byte load strobes for control bytes 0..2 |
| cfg_wdata | input | 8 | Byte value to load |
| addr | input | ADDR_W | Processor byte address |
| is_write | input | 1 | 1 = write access, 0 = read access |
| route_int | output | 1 | 1 = serve from DRAM, 0 = send to expansion bus/ROM |
| in_window | output | 1 | Address lies in the shadowable window |
| rom_shadowed | output | 1 | System ROM segment reads come from DRAM |

## Verification
On every cycle, the assertions check that out-of-window accesses route internal, that loads and holds of the control bytes follow the strobes, that a soft reset leaves the system ROM segment unshadowed and the 0xE0000 code untouched, and that `rom_shadowed` agrees with the routing of reads at 0xF0000. Only the bench scenarios can show the field-to-segment mapping and the read/write code decode. They sweep every segment under distinct codes at both ends of the segment. They also cover window edges, the inert low nibble of byte 2, and a soft reset that coincides with a write.

// File: rtl/shadow_router.sv
module shadow_router #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [2:0]        cfg_we,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output logic              route_int,
  output logic              in_window,
  output logic              rom_shadowed
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(20'hC0000);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(20'hFFFFF);

  logic [7:0] ctl_c, ctl_d, ctl_t;
  logic [1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_c <= '0;
      ctl_d <= '0;
      ctl_t <= '0;
    end else begin
      if (cfg_we[0]) ctl_c <= cfg_wdata;
      if (cfg_we[1]) ctl_d <= cfg_wdata;
      if (cfg_we[2]) ctl_t <= cfg_wdata;
      if (soft_rst)  ctl_t[5:4] <= 2'b00;
    end
  end

  always_comb begin
    case (addr[19:16])
      4'hC:    code = 2'(ctl_c >> {addr[15:14], 1'b0});
      4'hD:    code = 2'(ctl_d >> {addr[15:14], 1'b0});
      4'hE:    code = ctl_t[7:6];
      default: code = ctl_t[5:4];
    endcase
  end

  assign in_window    = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign route_int    = in_window ? (is_write ? code[0] : code[1]) : 1'b1;
  assign rom_shadowed = ctl_t[5];

  assert_outside_internal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_window |-> route_int);
  assert_load_byte0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we[0] |=> ctl_c == $past(cfg_wdata));
  assert_hold_byte1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we[1] |=> $stable(ctl_d));
  assert_load_byte2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we[2] && !soft_rst) |=> ctl_t == $past(cfg_wdata));
  assert_soft_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !rom_shadowed);
  assert_soft_keeps_e_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !cfg_we[2]) |=> $stable(ctl_t[7:6]));
  assert_flag_matches_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_window && addr[19:16] == 4'hF && !is_write) |-> route_int == rom_shadowed);
endmodule

// File: tb/shadow_router_tb_top.sv
`timescale 1ns/1ps
module shadow_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [2:0]  cfg_we = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] addr = '0;
  logic        is_write = 1'b0;
  logic        route_int, in_window, rom_shadowed;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [3];

  localparam logic [31:0] SEG_BASE [10] = '{32'hC0000, 32'hC4000, 32'hC8000, 32'hCC000,
                                            32'hD0000, 32'hD4000, 32'hD8000, 32'hDC000,
                                            32'hE0000, 32'hF0000};
  localparam logic [31:0] SEG_SIZE [10] = '{32'h4000, 32'h4000, 32'h4000, 32'h4000,
                                            32'h4000, 32'h4000, 32'h4000, 32'h4000,
                                            32'h10000, 32'h10000};
  localparam int SEG_BYTE [10] = '{0, 0, 0, 0, 1, 1, 1, 1, 2, 2};
  localparam int SEG_SH   [10] = '{0, 2, 4, 6, 0, 2, 4, 6, 6, 4};

  shadow_router dut_i (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .addr(addr), .is_write(is_write), .route_int(route_int),
    .in_window(in_window), .rom_shadowed(rom_shadowed));

  always #5 clk = ~clk;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic wr_cfg(input int idx, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 3'(1 << idx);
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = '0;
    m[idx] = v;
  endtask

  task automatic probe(input logic [31:0] a, input logic w);
    addr = a;
    is_write = w;
    #1;
  endtask

  function automatic logic exp_route(input int s, input logic w);
    logic [1:0] c = 2'(m[SEG_BYTE[s]] >> SEG_SH[s]);
    return w ? c[0] : c[1];
  endfunction

  initial begin
    m[0] = 0; m[1] = 0; m[2] = 0;
    repeat (3) @(negedge clk);
    probe(32'hC0000, 1'b0);
    check(route_int, 1'b0, "R1", "read C0000 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 10; s++) begin
      probe(SEG_BASE[s], 1'b0); check(route_int, 1'b0, "R1", "read after reset");
      probe(SEG_BASE[s], 1'b1); check(route_int, 1'b0, "R1", "write after reset");
    end
    check(rom_shadowed, 1'b0, "R1", "rom_shadowed after reset");

    // R3 R4 R5 sweep: each field gets a distinct rotating code
    for (int p = 0; p < 4; p++) begin
      logic [7:0] b0, b1, b2;
      for (int k = 0; k < 4; k++) begin
        b0[2*k +: 2] = 2'((p + k) % 4);
        b1[2*k +: 2] = 2'((p + k + 1) % 4);
      end
      b2 = {2'((p + 3) % 4), 2'((p + 2) % 4), 4'hA};
      wr_cfg(0, b0); wr_cfg(1, b1); wr_cfg(2, b2);
      for (int s = 0; s < 10; s++) begin
        for (int w = 0; w < 2; w++) begin
          probe(SEG_BASE[s], 1'(w));
          check(route_int, exp_route(s, 1'(w)), s < 8 ? "R3" : "R4", "segment start");
          probe(SEG_BASE[s] + SEG_SIZE[s] - 1, 1'(w));
          check(route_int, exp_route(s, 1'(w)), "R5", "segment end");
        end
      end
      check(rom_shadowed, m[2][5], "R7", "flag follows F code");
    end

    // R6 window edges
    probe(32'hBFFFF, 1'b0); check(in_window, 1'b0, "R6", "in_window BFFFF");
    check(route_int, 1'b1, "R6", "route BFFFF");
    probe(32'h100000, 1'b1); check(in_window, 1'b0, "R6", "in_window 100000");
    check(route_int, 1'b1, "R6", "route 100000");
    probe(32'h1C0000, 1'b0); check(in_window, 1'b0, "R6", "alias 1C0000");
    probe(32'hC0000, 1'b0); check(in_window, 1'b1, "R6", "in_window C0000");
    probe(32'hFFFFF, 1'b0); check(in_window, 1'b1, "R6", "in_window FFFFF");

    // R4 low nibble inert
    wr_cfg(2, 8'h0F);
    probe(32'hF8000, 1'b0); check(route_int, 1'b0, "R4", "low nibble F read");
    probe(32'hE8000, 1'b1); check(route_int, 1'b0, "R4", "low nibble E write");

    // R9 combinational response
    wr_cfg(0, 8'h02);
    addr = 32'hC1000; is_write = 1'b0; #1;
    check(route_int, 1'b1, "R9", "read same cycle");
    is_write = 1'b1; #1;
    check(route_int, 1'b0, "R9", "write same cycle");

    // R8 soft reset alone
    wr_cfg(0, 8'hFF); wr_cfg(2, 8'hF0);
    check(rom_shadowed, 1'b1, "R7", "flag set before soft reset");
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    m[2][5:4] = 2'b00;
    probe(32'hF0000, 1'b0); check(route_int, 1'b0, "R8", "F read after soft reset");
    probe(32'hF0000, 1'b1); check(route_int, 1'b0, "R8", "F write after soft reset");
    check(rom_shadowed, 1'b0, "R8", "flag after soft reset");
    probe(32'hE0000, 1'b0); check(route_int, 1'b1, "R8", "E kept");
    probe(32'hCC000, 1'b1); check(route_int, 1'b1, "R8", "byte0 kept");

    // R8 soft reset with concurrent write E=2 F=3
    @(negedge clk); soft_rst = 1'b1; cfg_we = 3'b100; cfg_wdata = 8'hB0;
    @(negedge clk); soft_rst = 1'b0; cfg_we = '0;
    probe(32'hF0000, 1'b0); check(route_int, 1'b0, "R8", "clear wins F read");
    probe(32'hE0000, 1'b0); check(route_int, 1'b1, "R8", "E loaded read");
    probe(32'hE0000, 1'b1); check(route_int, 1'b0, "R8", "E loaded write");

    // R2 hold without strobe
    @(negedge clk); cfg_wdata = 8'h00; @(negedge clk);
    probe(32'hC4000, 1'b0); check(route_int, 1'b1, "R2", "byte0 held");

    // R1 power-on reset again
    rst_n = 1'b0; #1;
    probe(32'hC4000, 1'b0); check(route_int, 1'b0, "R1", "byte0 cleared");
    probe(32'hE0000, 1'b0); check(route_int, 1'b0, "R1", "byte2 cleared");
    @(negedge clk); rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule